// File: doc/BRIEF.md
# Two-Channel Bus-Master Register Window

This block decodes a small I/O window that holds the bus-master DMA control registers for two disk channels. Each channel has eight bytes. The lower four bytes are byte-wide control registers: command, mode, status and drive timing. The upper four bytes hold a 32-bit descriptor-table base address. Both channels share one mode byte. Its interrupt-status bits follow level inputs from the channel interrupt sources, and only its two mask bits can be written.

A host access is a single cycle with a valid flag, a direction, a byte address and a size code. Reads return data combinationally in the same cycle. Writes take effect at the next rising clock edge. The DMA engine drives the busy, error and interrupt inputs. It uses the command start and direction bits, the descriptor base and the timing bytes as outputs. Each mode write raises a one-cycle update strobe so the interrupt unit can resample the mode byte.

Top module: `bm_regwin`

## Requirements
- R1: While reset is low, every register is zero: command, status, timing, descriptor base, mode byte and update strobe.
- R2: Address bit 3 selects the channel and address bit 2 selects the control group (0) or the descriptor base (1). In the control group, address bits 1:0 select command (0), mode (1), status (2) or timing (3). Writes to one channel never change the other channel's registers.
- R3: Size code 0 is one byte, 1 is two bytes, 2 is four bytes and 3 is reserved. In the control group, any access whose size is not one byte is ignored on write. On read it returns all-ones: 0xFF for byte, 0xFFFF for two bytes, 0xFFFFFFFF otherwise.
- R4: A byte write to offset 1 of either channel changes only mode bits 5:4 and keeps all other mode bits. Both channels read the same mode byte. Mode bits 7:6 and 1:0 are always zero.
- R5: The update strobe is high for exactly the one cycle after each mode write and stays low after any other access.
- R6: A status write sets bits 6:5 from the data and clears bit 1 and bit 2 wherever the data has a 1, otherwise keeping them. It forces bits 7, 4 and 3 to zero. Bit 0 cannot be written; it follows the channel busy input one cycle later.
- R7: An error-set or interrupt-set pulse from the engine sets status bit 1 or bit 2. If such a pulse arrives in the same cycle as a write that clears that bit, the bit is set.
- R8: A byte write to offset 3 stores that channel's own timing byte, which reads back and drives the channel's timing output.
- R9: A byte write to offset 0 stores the command byte. Command bit 0 drives the channel start output and bit 3 drives the channel direction output.
- R10: A four-byte write at channel offset 4 stores the data with bits 1:0 forced to zero, and a four-byte read returns it. Other sizes, or offsets 5 to 7, are ignored on write and read as all-ones of the access size.
- R11: Mode bit 2 follows channel 0's interrupt level input and mode bit 3 follows channel 1's, each one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Host access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 4 | Byte address in the window |
| acc_size | input | 2 | Size code: 0 byte, 1 two bytes, 2 four bytes, 3 reserved |
| acc_wdata | input | 32 | Write data, byte registers use bits 7:0 |
| acc_rdata | output | 32 | Read data, valid in the access cycle |
| eng_busy | input | 2 | Per-channel DMA active level |
| eng_err_set | input | 2 | Per-channel error pulse |
| eng_irq_set | input | 2 | Per-channel interrupt pulse |
| irq_lvl | input | 2 | Per-channel interrupt level for the mode byte |
| dma_start | output | 2 | Per-channel command bit 0 |
| dma_dir | output | 2 | Per-channel command bit 3 |
| desc_base | output | 64 | Descriptor base, channel 0 in bits 31:0 |
| drive_timing | output | 16 | Timing bytes, channel 0 in bits 7:0 |
| mode_byte | output | 8 | Shared mode byte |
| mode_upd | output | 1 | One-cycle strobe after a mode write |

## Verification
The bench builds the block with its default of two channels. This gives a 16-byte window with every address bit decoded, so each register of both channels and the shared mode alias are all reachable. With both channels present, the bench can write one channel and read the other to confirm they are isolated. It can also drive an engine set pulse in the same cycle as a host clear of the same status bit. The bench covers all four size codes on control, descriptor and misaligned offsets.

// File: rtl/bm_regwin_pkg.sv
package bm_regwin_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_MODE = 2'd1,
        SEL_STAT = 2'd2,
        SEL_TIME = 2'd3
    } ctrl_sel_e;

    localparam int unsigned CH_SPAN      = 8;
    localparam int unsigned CMD_START    = 0;
    localparam int unsigned CMD_DIR      = 3;
    localparam int unsigned ST_BUSY      = 0;
    localparam int unsigned ST_ERR       = 1;
    localparam int unsigned ST_IRQ       = 2;
    localparam logic [7:0]  ST_WR_MASK   = 8'h60;
    localparam logic [7:0]  ST_W1C_MASK  = 8'h06;
    localparam int unsigned MODE_IRQ_LSB = 2;
    localparam int unsigned MODE_IRQ_N   = 2;
    localparam int unsigned MODE_WR_LSB  = 4;

    typedef struct packed {
        logic [7:0]  cmd;
        logic [7:0]  stat;
        logic [7:0]  timing;
        logic [31:0] base;
    } chan_regs_t;

    typedef struct packed {
        logic [7:0] mode;
        logic       upd;
    } mode_state_t;

endpackage

// File: rtl/bm_addr_decode.sv
module bm_addr_decode
    import bm_regwin_pkg::*;
#(
    parameter  int NUM_CH = 2,
    localparam int ADDR_W = $clog2(NUM_CH * CH_SPAN),
    localparam int CH_W   = $clog2(NUM_CH)
) (
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    output logic              acc_ok,
    output logic              is_ctrl,
    output ctrl_sel_e         reg_sel,
    output logic [CH_W-1:0]   ch_idx,
    output logic              mode_we,
    output logic [NUM_CH-1:0] cmd_we,
    output logic [NUM_CH-1:0] stat_we,
    output logic [NUM_CH-1:0] time_we,
    output logic [NUM_CH-1:0] base_we
);

    logic wr_ok;

    always_comb begin
        ch_idx  = acc_addr[ADDR_W-1:3];
        is_ctrl = ~acc_addr[2];
        reg_sel = ctrl_sel_e'(acc_addr[1:0]);
        if (is_ctrl) begin
            acc_ok = (acc_size == SZ_BYTE);
        end else begin
            acc_ok = (acc_size == SZ_WORD) && (acc_addr[1:0] == 2'b00);
        end
        wr_ok   = acc_valid && acc_write && acc_ok;
        mode_we = wr_ok && is_ctrl && (reg_sel == SEL_MODE);
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_we
        logic hit;
        assign hit        = wr_ok && (ch_idx == CH_W'(c));
        assign cmd_we[c]  = hit && is_ctrl && (reg_sel == SEL_CMD);
        assign stat_we[c] = hit && is_ctrl && (reg_sel == SEL_STAT);
        assign time_we[c] = hit && is_ctrl && (reg_sel == SEL_TIME);
        assign base_we[c] = hit && !is_ctrl;
    end

endmodule

// File: rtl/bm_chan_regs.sv
module bm_chan_regs
    import bm_regwin_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] wdata,
    input  logic        cmd_we,
    input  logic        stat_we,
    input  logic        time_we,
    input  logic        base_we,
    input  logic        busy,
    input  logic        err_set,
    input  logic        irq_set,
    output chan_regs_t  regs_q
);

    chan_regs_t regs_d;

    always_comb begin
        regs_d = regs_q;
        if (cmd_we) begin
            regs_d.cmd = wdata[7:0];
        end
        if (stat_we) begin
            regs_d.stat = (wdata[7:0] & ST_WR_MASK)
                        | (regs_q.stat & ~wdata[7:0] & ST_W1C_MASK);
        end
        // busy is owned by the engine, never by the host
        regs_d.stat[ST_BUSY] = busy;
        // engine events win over a same-cycle host clear
        if (err_set) begin
            regs_d.stat[ST_ERR] = 1'b1;
        end
        if (irq_set) begin
            regs_d.stat[ST_IRQ] = 1'b1;
        end
        if (time_we) begin
            regs_d.timing = wdata[7:0];
        end
        if (base_we) begin
            regs_d.base = {wdata[31:2], 2'b00};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

endmodule

// File: rtl/bm_mode_reg.sv
module bm_mode_reg
    import bm_regwin_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_we,
    input  logic [1:0]            wbits,
    input  logic [MODE_IRQ_N-1:0] irq_lvl,
    output logic [7:0]            mode_q,
    output logic                  upd_q
);

    mode_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < MODE_IRQ_N; i++) begin
            st_d.mode[MODE_IRQ_LSB + i] = irq_lvl[i];
        end
        if (mode_we) begin
            st_d.mode[MODE_WR_LSB +: 2] = wbits;
        end
        st_d.upd = mode_we;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_q = st_q.mode;
    assign upd_q  = st_q.upd;

endmodule

// File: rtl/bm_regwin.sv
module bm_regwin
    import bm_regwin_pkg::*;
#(
    parameter  int NUM_CH = 2,
    localparam int ADDR_W = $clog2(NUM_CH * CH_SPAN),
    localparam int CH_W   = $clog2(NUM_CH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   acc_valid,
    input  logic                   acc_write,
    input  logic [ADDR_W-1:0]      acc_addr,
    input  logic [1:0]             acc_size,
    input  logic [31:0]            acc_wdata,
    output logic [31:0]            acc_rdata,
    input  logic [NUM_CH-1:0]      eng_busy,
    input  logic [NUM_CH-1:0]      eng_err_set,
    input  logic [NUM_CH-1:0]      eng_irq_set,
    input  logic [MODE_IRQ_N-1:0]  irq_lvl,
    output logic [NUM_CH-1:0]      dma_start,
    output logic [NUM_CH-1:0]      dma_dir,
    output logic [NUM_CH*32-1:0]   desc_base,
    output logic [NUM_CH*8-1:0]    drive_timing,
    output logic [7:0]             mode_byte,
    output logic                   mode_upd
);

    logic              acc_ok;
    logic              is_ctrl;
    ctrl_sel_e         reg_sel;
    logic [CH_W-1:0]   ch_idx;
    logic              mode_we;
    logic [NUM_CH-1:0] cmd_we, stat_we, time_we, base_we;
    chan_regs_t        regs [NUM_CH];
    logic [NUM_CH*8-1:0] stat_all;

    bm_addr_decode #(.NUM_CH(NUM_CH)) u_dec (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .acc_size  (acc_size),
        .acc_ok    (acc_ok),
        .is_ctrl   (is_ctrl),
        .reg_sel   (reg_sel),
        .ch_idx    (ch_idx),
        .mode_we   (mode_we),
        .cmd_we    (cmd_we),
        .stat_we   (stat_we),
        .time_we   (time_we),
        .base_we   (base_we)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        bm_chan_regs u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wdata   (acc_wdata),
            .cmd_we  (cmd_we[c]),
            .stat_we (stat_we[c]),
            .time_we (time_we[c]),
            .base_we (base_we[c]),
            .busy    (eng_busy[c]),
            .err_set (eng_err_set[c]),
            .irq_set (eng_irq_set[c]),
            .regs_q  (regs[c])
        );
        assign dma_start[c]          = regs[c].cmd[CMD_START];
        assign dma_dir[c]            = regs[c].cmd[CMD_DIR];
        assign desc_base[c*32 +: 32] = regs[c].base;
        assign drive_timing[c*8 +: 8] = regs[c].timing;
        assign stat_all[c*8 +: 8]    = regs[c].stat;
    end

    bm_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_we (mode_we),
        .wbits   (acc_wdata[MODE_WR_LSB +: 2]),
        .irq_lvl (irq_lvl),
        .mode_q  (mode_byte),
        .upd_q   (mode_upd)
    );

    // read path: unsupported accesses return all-ones of the access size
    logic [31:0] ones;
    logic [7:0]  ctrl_byte;

    always_comb begin
        case (acc_size)
            SZ_BYTE: ones = 32'h0000_00FF;
            SZ_HALF: ones = 32'h0000_FFFF;
            default: ones = 32'hFFFF_FFFF;
        endcase
        case (reg_sel)
            SEL_CMD:  ctrl_byte = regs[ch_idx].cmd;
            SEL_MODE: ctrl_byte = mode_byte;
            SEL_STAT: ctrl_byte = regs[ch_idx].stat;
            default:  ctrl_byte = regs[ch_idx].timing;
        endcase
        if (!acc_ok) begin
            acc_rdata = ones;
        end else if (is_ctrl) begin
            acc_rdata = {24'h0, ctrl_byte};
        end else begin
            acc_rdata = regs[ch_idx].base;
        end
    end

endmodule

// File: rtl/bm_regwin_chk.sv
module bm_regwin_chk
    import bm_regwin_pkg::*;
#(
    parameter  int NUM_CH = 2,
    localparam int ADDR_W = $clog2(NUM_CH * CH_SPAN)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 acc_valid,
    input logic                 acc_write,
    input logic [ADDR_W-1:0]    acc_addr,
    input logic [1:0]           acc_size,
    input logic [31:0]          acc_wdata,
    input logic [31:0]          acc_rdata,
    input logic [NUM_CH-1:0]    eng_busy,
    input logic [NUM_CH-1:0]    dma_start,
    input logic [NUM_CH*32-1:0] desc_base,
    input logic [7:0]           mode_byte,
    input logic                 mode_upd,
    input logic [NUM_CH*8-1:0]  stat_all
);

    logic mode_wr;
    assign mode_wr = acc_valid && acc_write && (acc_size == SZ_BYTE)
                   && !acc_addr[2] && (acc_addr[1:0] == 2'd1);

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_clear_r1: assert (dma_start == '0 && mode_byte == 8'h00
                                      && desc_base == '0 && !mode_upd)
                else $error("R1 register not cleared in reset");
        end
    end

    p_mode_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_byte & 8'hC3) == 8'h00);

    p_upd_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> mode_upd);

    p_upd_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_upd |-> $past(mode_wr));

    p_unsup_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && !acc_addr[2] && acc_size != SZ_BYTE)
        |-> acc_rdata[15:0] == 16'hFFFF);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        p_busy_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
            stat_all[c*8 + ST_BUSY] == $past(eng_busy[c]));

        p_stat_rsvd_r6: assert property (@(posedge clk) disable iff (!rst_n)
            stat_all[c*8 + 7] == 1'b0 && stat_all[c*8 + 3 +: 2] == 2'b00);

        p_base_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_valid && acc_write && acc_size == SZ_WORD
             && acc_addr == ADDR_W'(c*CH_SPAN + 4))
            |=> desc_base[c*32 +: 32] == ($past(acc_wdata) & 32'hFFFF_FFFC));
    end

endmodule

bind bm_regwin bm_regwin_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_size  (acc_size),
    .acc_wdata (acc_wdata),
    .acc_rdata (acc_rdata),
    .eng_busy  (eng_busy),
    .dma_start (dma_start),
    .desc_base (desc_base),
    .mode_byte (mode_byte),
    .mode_upd  (mode_upd),
    .stat_all  (stat_all)
);

// File: tb/sim_bm_regwin.sv
`timescale 1ns/1ps
module sim_bm_regwin;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [3:0]  acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic [1:0]  eng_busy = '0;
    logic [1:0]  eng_err_set = '0;
    logic [1:0]  eng_irq_set = '0;
    logic [1:0]  irq_lvl = '0;
    logic [1:0]  dma_start, dma_dir;
    logic [63:0] desc_base;
    logic [15:0] drive_timing;
    logic [7:0]  mode_byte;
    logic        mode_upd;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bm_regwin u0 (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_size(acc_size), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .eng_busy(eng_busy), .eng_err_set(eng_err_set), .eng_irq_set(eng_irq_set),
        .irq_lvl(irq_lvl), .dma_start(dma_start), .dma_dir(dma_dir),
        .desc_base(desc_base), .drive_timing(drive_timing),
        .mode_byte(mode_byte), .mode_upd(mode_upd)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_size = sz; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [1:0] sz,
                      input logic [31:0] exp, input string req);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a; acc_size = sz;
        #2;
        check(req, acc_rdata, exp);
        acc_valid = 1'b0;
    endtask

    task automatic t_reset;
        for (int a = 0; a < 16; a++) begin
            if ((a & 4) == 0) rd(4'(a), 2'd0, 32'h0, "R1 control byte after reset");
        end
        rd(4'd4, 2'd2, 32'h0, "R1 base ch0 after reset");
        check("R1 outputs after reset", {dma_start, dma_dir, mode_byte, drive_timing, 7'd0, mode_upd}, 64'h0);
        check("R1 base outputs after reset", desc_base, 64'h0);
    endtask

    task automatic t_command;
        wr(4'd0, 2'd0, 32'h0000_0009);
        check("R9 start/dir after ch0 cmd 0x09", {dma_start, dma_dir}, {2'b01, 2'b01});
        rd(4'd0, 2'd0, 32'h09, "R9 ch0 cmd readback");
        rd(4'd8, 2'd0, 32'h00, "R2 ch1 cmd untouched");
        wr(4'd8, 2'd0, 32'h0000_0008);
        check("R9 ch1 dir only", {dma_start, dma_dir}, {2'b01, 2'b11});
        check("R5 no strobe after cmd write", mode_upd, 1'b0);
    endtask

    task automatic t_mode;
        wr(4'd1, 2'd0, 32'h0000_00FF);
        check("R5 strobe after mode write", mode_upd, 1'b1);
        @(negedge clk);
        check("R5 strobe one cycle", mode_upd, 1'b0);
        rd(4'd9, 2'd0, 32'h30, "R4 mode alias via ch1 only bits 5:4");
        @(negedge clk); irq_lvl = 2'b01;
        rd(4'd1, 2'd0, 32'h34, "R11 ch0 irq level to bit 2");
        @(negedge clk); irq_lvl = 2'b10;
        rd(4'd9, 2'd0, 32'h38, "R11 ch1 irq level to bit 3");
        wr(4'd9, 2'd0, 32'h0000_00D3);
        check("R4 mode write keeps irq bit", mode_byte, 8'h18);
        @(negedge clk); irq_lvl = 2'b00;
        @(negedge clk);
        check("R11 levels dropped", mode_byte, 8'h10);
    endtask

    task automatic t_status;
        @(negedge clk); eng_busy = 2'b01; eng_err_set = 2'b01; eng_irq_set = 2'b01;
        @(negedge clk); eng_err_set = 2'b00; eng_irq_set = 2'b00;
        rd(4'd2, 2'd0, 32'h07, "R7 engine sets err/irq, R6 busy");
        rd(4'd10, 2'd0, 32'h00, "R2 ch1 status untouched");
        wr(4'd2, 2'd0, 32'h0000_0062);
        rd(4'd2, 2'd0, 32'h65, "R6 write 0x62 over 0x07");
        wr(4'd2, 2'd0, 32'h0000_009C);
        rd(4'd2, 2'd0, 32'h01, "R6 write 0x9C over 0x65");
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 4'd2; acc_size = 2'd0;
        acc_wdata = 32'h02; eng_err_set = 2'b01;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; eng_err_set = 2'b00;
        rd(4'd2, 2'd0, 32'h03, "R7 set wins over same-cycle clear");
        @(negedge clk); eng_busy = 2'b00;
        wr(4'd2, 2'd0, 32'h0000_0001);
        rd(4'd2, 2'd0, 32'h02, "R6 bit 0 not host-writable");
    endtask

    task automatic t_timing;
        wr(4'd3, 2'd0, 32'h0000_00A5);
        wr(4'd11, 2'd0, 32'h0000_003C);
        rd(4'd3, 2'd0, 32'hA5, "R8 ch0 timing");
        rd(4'd11, 2'd0, 32'h3C, "R8 ch1 timing");
        check("R8 timing outputs", drive_timing, 16'h3CA5);
    endtask

    task automatic t_unsupported;
        rd(4'd0, 2'd1, 32'h0000_FFFF, "R3 half read of control");
        rd(4'd2, 2'd2, 32'hFFFF_FFFF, "R3 word read of control");
        rd(4'd11, 2'd3, 32'hFFFF_FFFF, "R3 reserved size read");
        wr(4'd3, 2'd1, 32'h0000_0000);
        rd(4'd3, 2'd0, 32'hA5, "R3 half write ignored");
        wr(4'd8, 2'd2, 32'h0000_0000);
        check("R3 word write to cmd ignored", dma_dir, 2'b11);
    endtask

    task automatic t_base;
        wr(4'd4, 2'd2, 32'h1234_567B);
        rd(4'd4, 2'd2, 32'h1234_5678, "R10 ch0 base low bits zero");
        wr(4'd12, 2'd2, 32'hDEAD_BEEF);
        rd(4'd12, 2'd2, 32'hDEAD_BEEC, "R10 ch1 base");
        check("R10 base outputs", desc_base, 64'hDEAD_BEEC_1234_5678);
        wr(4'd5, 2'd0, 32'h0000_0000);
        wr(4'd4, 2'd1, 32'h0000_0000);
        wr(4'd6, 2'd2, 32'h0000_0000);
        rd(4'd4, 2'd2, 32'h1234_5678, "R10 narrow/misaligned writes ignored");
        rd(4'd4, 2'd0, 32'h0000_00FF, "R10 byte read of base is all-ones");
    endtask

    task automatic t_reset_again;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 outputs in reset", {dma_start, dma_dir, drive_timing, mode_byte}, 64'h0);
        check("R1 base in reset", desc_base, 64'h0);
        @(negedge clk); rst_n = 1'b1;
        rd(4'd2, 2'd0, 32'h00, "R1 status after reset");
    endtask

    initial begin
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_command();
        t_mode();
        t_status();
        t_timing();
        t_unsupported();
        t_base();
        t_reset_again();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule